// File: doc/BRIEF.md
# ADC Readout Word Formatter and Transmitter

This block turns one channel's worth of converter samples into a framed record of 32-bit words and sends it to a downstream receiver. Each word pairs one 10-bit sample from the lower converter half with one from the upper half. Each 16-bit half carries framing bits. The record always has a fixed number of words. The receiver sees a word bus, a valid strobe that spans the whole record, and a transfer clock. The block derives that clock from the system clock and gates it.

A single-cycle start request latches the format mode, the 4-bit event tag and the 4-bit channel number. Samples are pulled by address. The block presents the index of the pair it wants next, and the sample store answers with that pair at the same time. The transfer clock always skips its first pulse after valid rises, which gives a slow receiver time to get ready. Words change only on falling transfer-clock edges, so every rising edge finds a settled word. After the last word has been taken, valid drops and the block goes back to idle.

Top module: `adc_word_tx`

## Requirements
- R1: After reset, and whenever valid_o is low, word_o is all zeros and xclk_o is low. smp_addr_o is zero after reset.
- R2: In idle, a start_i high at a clock edge latches mode_i, event_i and chan_i and raises valid_o at that same edge, with word 0 on word_o. A start_i that arrives while a record is in flight is ignored: the latched fields do not change and no extra record follows.
- R3: In standard format (mode_i = 0), each 16-bit half is laid out as start[15], event[14:11], sample[10:1], stop[0]. The lower half carries the lower sample and the upper half carries the upper sample.
- R4: The start flag is 1 only in word 0 and the stop flag is 1 only in the last word (word 127 by default). In tagged format only the lower half carries these flags.
- R5: In tagged format (mode_i = 1), the lower half keeps the R3 layout. The upper half is channel[31:28], upper sample[27:18], parity[17], and bit 16 is zero.
- R6: In tagged format, the parity bit makes the total number of ones in the 32-bit word even.
- R7: While valid_o is high, xclk_o has a period of 2*HALF_CYC system clocks with equal high and low times. xclk_o is never high while valid_o is low.
- R8: The first internal transfer-clock pulse after valid_o rises is suppressed. The first visible rising edge of xclk_o comes exactly 3*HALF_CYC system clocks after valid_o rises, and there is no edge before it.
- R9: Each record has exactly WORDS rising edges of xclk_o. Word k is on the bus at rising edge k+1, and word_o changes only together with a falling edge of xclk_o.
- R10: smp_addr_o is the index of the sample pair the block will load next. The pair presented at index k appears in word k. smp_addr_o is 1 while word 0 is on the bus, and wraps to 0 while the last word is on the bus.
- R11: valid_o falls HALF_CYC system clocks after the rising edge that carries the last word, at the same edge where xclk_o falls. A new start is accepted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send one record (taken only in idle) |
| mode_i | input | 1 | Format select: 0 standard, 1 tagged with channel and parity |
| event_i | input | 4 | Event tag from the trigger system |
| chan_i | input | 4 | Channel number used in tagged format |
| lo_smp_i | input | 10 | Lower-half sample at index smp_addr_o |
| hi_smp_i | input | 10 | Upper-half sample at index smp_addr_o |
| smp_addr_o | output | 7 | Index of the sample pair loaded next |
| valid_o | output | 1 | High for the whole record |
| xclk_o | output | 1 | Gated transfer clock, first pulse suppressed |
| word_o | output | 32 | Outgoing data word |

## Verification
The hardest case to reach from the ports is a start request that arrives while a record is in flight. It must change neither the latched tag, the channel nor the record count. The bench pulses start_i in the middle of a record, with a different tag and channel on the inputs. It then checks every later word against the first tag, and it checks that valid_o stays low after the record ends. The timing of the suppressed first pulse and of the final valid drop is measured in system-clock cycles from valid_o. Both format modes are run with all-zero, all-one and random sample patterns.

// File: rtl/adc_tx_pkg.sv
package adc_tx_pkg;
    localparam int SMP_W  = 10;
    localparam int TAG_W  = 4;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic {
        FMT_PAIRED = 1'b0,
        FMT_TAGGED = 1'b1
    } fmt_e;
endpackage

// File: rtl/adc_tx_clkgen.sv
module adc_tx_clkgen #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_rise_o,
    output logic tick_fall_o
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } gen_t;

    gen_t gen_d, gen_q;
    logic wrap;

    assign wrap        = run_i && (gen_q.cnt == CNT_END);
    assign tick_rise_o = wrap && !gen_q.ph;
    assign tick_fall_o = wrap && gen_q.ph;

    always_comb begin
        gen_d = gen_q;
        if (!run_i) begin
            gen_d.cnt = '0;
            gen_d.ph  = 1'b0;
        end else if (wrap) begin
            gen_d.cnt = '0;
            gen_d.ph  = !gen_q.ph;
        end else begin
            gen_d.cnt = gen_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end
endmodule

// File: rtl/adc_tx_pack.sv
module adc_tx_pack
    import adc_tx_pkg::*;
(
    input  fmt_e              mode_i,
    input  logic              first_i,
    input  logic              last_i,
    input  logic [TAG_W-1:0]  event_i,
    input  logic [TAG_W-1:0]  chan_i,
    input  logic [SMP_W-1:0]  lo_i,
    input  logic [SMP_W-1:0]  hi_i,
    output logic [WORD_W-1:0] word_o
);
    logic [HALF_W-1:0] lo_half, hi_std, hi_tag;
    logic [WORD_W-1:0] raw_tag;

    always_comb begin
        lo_half = {first_i, event_i, lo_i, last_i};
        hi_std  = {first_i, event_i, hi_i, last_i};
        hi_tag  = {chan_i, hi_i, 2'b00};
        raw_tag = {hi_tag, lo_half};
        if (mode_i == FMT_TAGGED) begin
            word_o     = raw_tag;
            word_o[17] = ^raw_tag;
        end else begin
            word_o = {hi_std, lo_half};
        end
    end
endmodule

// File: rtl/adc_word_tx.sv
module adc_word_tx
    import adc_tx_pkg::*;
#(
    parameter int WORDS    = 128,
    parameter int HALF_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        mode_i,
    input  logic [3:0]  event_i,
    input  logic [3:0]  chan_i,
    input  logic [9:0]  lo_smp_i,
    input  logic [9:0]  hi_smp_i,
    output logic [6:0]  smp_addr_o,
    output logic        valid_o,
    output logic        xclk_o,
    output logic [31:0] word_o
);
    localparam int IDXW = $clog2(WORDS);
    localparam logic [IDXW-1:0] LAST = IDXW'(WORDS - 1);

    typedef struct packed {
        logic              valid;
        logic              xclk;
        logic              skip;
        fmt_e              mode;
        logic [TAG_W-1:0]  ev;
        logic [TAG_W-1:0]  ch;
        logic [IDXW-1:0]   idx;
        logic [IDXW-1:0]   addr;
        logic [WORD_W-1:0] word;
    } tx_t;

    tx_t st_d, st_q;

    logic              tick_rise, tick_fall;
    fmt_e              pk_mode;
    logic [TAG_W-1:0]  pk_ev, pk_ch;
    logic [IDXW-1:0]   pk_idx;
    logic [WORD_W-1:0] pk_word;

    adc_tx_clkgen #(.HALF_CYC(HALF_CYC)) u_clkgen (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (st_q.valid),
        .tick_rise_o (tick_rise),
        .tick_fall_o (tick_fall)
    );

    assign pk_mode = st_q.valid ? st_q.mode : fmt_e'(mode_i);
    assign pk_ev   = st_q.valid ? st_q.ev   : event_i;
    assign pk_ch   = st_q.valid ? st_q.ch   : chan_i;
    assign pk_idx  = st_q.valid ? (st_q.idx + IDXW'(1)) : '0;

    adc_tx_pack u_pack (
        .mode_i  (pk_mode),
        .first_i (pk_idx == '0),
        .last_i  (pk_idx == LAST),
        .event_i (pk_ev),
        .chan_i  (pk_ch),
        .lo_i    (lo_smp_i),
        .hi_i    (hi_smp_i),
        .word_o  (pk_word)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.valid) begin
            if (start_i) begin
                st_d.valid = 1'b1;
                st_d.xclk  = 1'b0;
                st_d.skip  = 1'b1;
                st_d.mode  = fmt_e'(mode_i);
                st_d.ev    = event_i;
                st_d.ch    = chan_i;
                st_d.idx   = '0;
                st_d.addr  = (LAST == '0) ? '0 : IDXW'(1);
                st_d.word  = pk_word;
            end
        end else begin
            if (tick_rise) begin
                if (st_q.skip) st_d.skip = 1'b0;
                else           st_d.xclk = 1'b1;
            end
            if (tick_fall && st_q.xclk) begin
                st_d.xclk = 1'b0;
                if (st_q.idx == LAST) begin
                    st_d.valid = 1'b0;
                    st_d.idx   = '0;
                    st_d.addr  = '0;
                    st_d.word  = '0;
                end else begin
                    st_d.idx  = st_q.idx + IDXW'(1);
                    st_d.addr = (st_q.addr == LAST) ? '0 : st_q.addr + IDXW'(1);
                    st_d.word = pk_word;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign smp_addr_o = 7'(st_q.addr);
    assign valid_o    = st_q.valid;
    assign xclk_o     = st_q.xclk;
    assign word_o     = st_q.word;
endmodule

// File: rtl/adc_word_tx_chk.sv
module adc_word_tx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        valid,
    input logic        xclk,
    input logic [31:0] word,
    input logic [6:0]  addr,
    input logic        mode
);
    p_idle_bus_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (word == 32'd0 && !xclk));

    p_clk_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xclk |-> valid);

    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xclk && $past(xclk)) |-> $stable(word));

    p_first_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && word[15]) |-> (addr == 7'd1));

    p_last_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && word[0]) |-> (addr == 7'd0));

    p_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode) |-> !(^word));

    p_end_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid) |-> $fell(xclk));
endmodule

bind adc_word_tx adc_word_tx_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (valid_o),
    .xclk  (xclk_o),
    .word  (word_o),
    .addr  (smp_addr_o),
    .mode  (st_q.mode)
);

// File: tb/test_adc_word_tx.sv
module test_adc_word_tx;
    localparam int WORDS = 128;
    localparam int HC    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [3:0]  ev = 4'd0, ch = 4'd0;
    logic [9:0]  lo_smp, hi_smp;
    logic [6:0]  smp_addr;
    logic        valid, xclk;
    logic [31:0] word;

    logic [9:0] lo_mem [0:WORDS-1];
    logic [9:0] hi_mem [0:WORDS-1];
    assign lo_smp = lo_mem[smp_addr];
    assign hi_smp = hi_mem[smp_addr];

    int tests = 0, fails = 0;
    int cyc = 0, vrise_cyc = 0, last_rise_cyc = 0, rcount = 0, done_cnt = 0;
    logic prev_v = 1'b0, prev_x = 1'b0, gate_bad = 1'b0;
    logic       x_mode;
    logic [3:0] x_ev, x_ch;

    always #4 clk = !clk;

    adc_word_tx i_adc_word_tx (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .event_i(ev), .chan_i(ch), .lo_smp_i(lo_smp), .hi_smp_i(hi_smp),
        .smp_addr_o(smp_addr), .valid_o(valid), .xclk_o(xclk), .word_o(word)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int k, input logic m,
            input logic [3:0] e, input logic [3:0] c, input logic [9:0] lo, input logic [9:0] hi);
        logic s, p;
        logic [31:0] w;
        s = (k == 0);
        p = (k == WORDS - 1);
        w = '0;
        w[15] = s; w[14:11] = e; w[10:1] = lo; w[0] = p;
        if (!m) begin
            w[31] = s; w[30:27] = e; w[26:17] = hi; w[16] = p;
        end else begin
            w[31:28] = c; w[27:18] = hi;
            w[17] = ^w;
        end
        return w;
    endfunction

    always @(negedge clk) begin
        cyc++;
        if (!valid && xclk) gate_bad = 1'b1;
        if (valid && !prev_v) begin
            vrise_cyc = cyc;
            rcount = 0;
        end
        if (xclk && !prev_x) begin
            if (rcount == 0)
                check(cyc - vrise_cyc == 3*HC, "R8 first visible edge", cyc - vrise_cyc, 3*HC);
            else
                check(cyc - last_rise_cyc == 2*HC, "R7 xclk period", cyc - last_rise_cyc, 2*HC);
            if (rcount < WORDS) begin
                logic [31:0] e;
                e = exp_word(rcount, x_mode, x_ev, x_ch, lo_mem[rcount], hi_mem[rcount]);
                check(word == e, "R3 R5 R10 word content", word, e);
                check(word[15] == (rcount == 0) && word[0] == (rcount == WORDS-1),
                      "R4 flag position", word, e);
                if (x_mode) check(!(^word), "R6 even parity", word, e);
            end
            last_rise_cyc = cyc;
            rcount++;
        end
        if (!valid && prev_v) begin
            check(rcount == WORDS, "R9 rising edges per record", rcount, WORDS);
            check(cyc - last_rise_cyc == HC, "R11 valid drop timing", cyc - last_rise_cyc, HC);
            check(!xclk && word == 0, "R1 idle bus after record", word, 0);
            check(!gate_bad, "R7 clock gated by valid", gate_bad, 0);
            done_cnt++;
        end
        prev_v = valid;
        prev_x = xclk;
    end

    task automatic run_record(input logic m, input logic [3:0] e, input logic [3:0] c,
                              input int pat, input bit poke);
        int target;
        for (int k = 0; k < WORDS; k++) begin
            case (pat)
                0: begin lo_mem[k] = 10'h000; hi_mem[k] = 10'h000; end
                1: begin lo_mem[k] = 10'h3FF; hi_mem[k] = 10'h3FF; end
                default: begin lo_mem[k] = 10'($urandom); hi_mem[k] = 10'($urandom); end
            endcase
        end
        x_mode = m; x_ev = e; x_ch = c;
        target = done_cnt + 1;
        @(negedge clk);
        mode = m; ev = e; ch = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(valid == 1'b1, "R2 valid after start", valid, 1);
        check(smp_addr == 7'd1, "R10 address after start", smp_addr, 1);
        if (poke) begin
            repeat (300) @(negedge clk);
            mode = !m; ev = ~e; ch = ~c; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (done_cnt == target);
        repeat (5) @(negedge clk);
        check(valid == 1'b0, "R2 no extra record from busy start", valid, 0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < WORDS; k++) begin lo_mem[k] = '0; hi_mem[k] = '0; end
        repeat (3) @(negedge clk);
        check(!valid && !xclk && word == 0 && smp_addr == 0, "R1 reset state", word, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        run_record(1'b0, 4'h5, 4'h3, 2, 1'b0);
        run_record(1'b1, 4'hA, 4'hC, 2, 1'b1);
        run_record(1'b0, 4'h0, 4'h0, 0, 1'b1);
        run_record(1'b1, 4'hF, 4'hF, 1, 1'b0);
        run_record(1'b1, 4'h0, 4'h0, 0, 1'b0);
        run_record(1'b0, 4'hF, 4'h9, 1, 1'b0);
        for (int r = 0; r < 4; r++)
            run_record(1'($urandom), 4'($urandom), 4'($urandom), 2, r[0]);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule